// File: doc/BRIEF.md
# Shift and Rotate Unit

This block performs single-step shift and rotate operations on an operand of 8, 16 or 32 bits held in the low end of a 32-bit data word. One operation is selected per transaction: logical shifts, arithmetic shifts, plain rotates, rotates through the carry flag, or a bitwise inversion. A single count bit chooses whether the operation moves the data by one or by two positions. The block returns the new data word together with negative, zero, overflow and carry flags.

A transaction is presented with `in_valid` high for one cycle. The result and flags are captured on that clock edge and shown with `out_valid` high during the following cycle. They then hold until the next accepted transaction. The asynchronous active-low reset is released through a two-stage synchronizer, so the unit accepts work from the third rising edge after `rst_n` goes high.

Top module: `shift_rotate_unit`

## Requirements
- R1: `in_two` = 0 moves the operand by one position and `in_two` = 1 moves it by two positions, for every shift and rotate code (0 to 7).
- R2: Logical left (code 0) and logical right (code 1) fill vacated bits with zero and clear V. C takes the last bit moved out: bit width-1 (or width-2 when the count is two) for left, bit 0 (or bit 1) for right.
- R3: Arithmetic left (code 2) produces the same data and C as logical left. V is set when the top count+1 bits of the operand are not all equal, which means the sign changed at some step.
- R4: Arithmetic right (code 3) copies the sign bit into each vacated position, clears V and sets C to the last bit moved out.
- R5: Rotate left through carry (code 6) and rotate right through carry (code 7) each act on a ring of width+1 bits made of the operand and C. Each step puts the old C into the vacated end and the bit moved out into C. The step is repeated when the count is two. V is cleared.
- R6: Rotate left (code 4) and rotate right (code 5) move each outgoing bit to the opposite end and copy the last one into C. V is cleared.
- R7: Inversion (code 8) inverts the operand, clears V, leaves C equal to `in_carry` and ignores `in_two`. Codes 9 to 15 pass the operand through unchanged, with V clear and C equal to `in_carry`.
- R8: N is bit width-1 of the result. Z is set exactly when all width bits of the result are zero.
- R9: `in_size` selects the width: 0 is 8 bits, 1 is 16 bits, and 2 or 3 is 32 bits. Bits of `in_data` above the selected width appear unchanged in `out_data`.
- R10: `out_valid` is high in the cycle after each cycle with `in_valid` high and low otherwise. Without `in_valid`, `out_data` and the flags hold. After reset `out_valid`, `out_data` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Transaction strobe |
| in_op | input | 4 | Operation code |
| in_size | input | 2 | Operand width select |
| in_two | input | 1 | Count select: 0 one position, 1 two positions |
| in_data | input | 32 | Data word carrying the operand in its low bits |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result valid |
| out_data | output | 32 | Result word |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_c | output | 1 | Carry flag |

## Verification
The assertions check the following on every cycle:
- the valid timing and output hold of R10;
- that V stays clear for every code other than arithmetic left (R2, R4 to R7);
- that inversion keeps the incoming carry (R7);
- that the upper bits pass through for byte-width operations (R9).

The data values, the last-bit-out carry, the sign-change overflow of R3 and the through-carry ring of R5 can only be shown by the bench's scenarios. The bench sweeps every byte operand under every code, count and carry, then runs patterned 16- and 32-bit operands against an arithmetic model.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [3:0] {
    OP_SHL = 4'd0,
    OP_SHR = 4'd1,
    OP_SAL = 4'd2,
    OP_SAR = 4'd3,
    OP_ROL = 4'd4,
    OP_ROR = 4'd5,
    OP_RCL = 4'd6,
    OP_RCR = 4'd7,
    OP_NOT = 4'd8
  } shrot_op_e;
endpackage

// File: rtl/shrot_step.sv
module shrot_step
  import shrot_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  input  logic         cin,
  input  shrot_op_e    op,
  output logic [W-1:0] dout,
  output logic         cout
);
  // One position of movement for the selected operation.
  always_comb begin
    dout = din;
    cout = cin;
    case (op)
      OP_SHL, OP_SAL: begin dout = {din[W-2:0], 1'b0};     cout = din[W-1]; end
      OP_SHR:         begin dout = {1'b0, din[W-1:1]};     cout = din[0];   end
      OP_SAR:         begin dout = {din[W-1], din[W-1:1]}; cout = din[0];   end
      OP_ROL:         begin dout = {din[W-2:0], din[W-1]}; cout = din[W-1]; end
      OP_ROR:         begin dout = {din[0], din[W-1:1]};   cout = din[0];   end
      OP_RCL:         begin dout = {din[W-2:0], cin};      cout = din[W-1]; end
      OP_RCR:         begin dout = {cin, din[W-1:1]};      cout = din[0];   end
      OP_NOT:         begin dout = ~din;                   cout = cin;      end
      default:        begin dout = din;                    cout = cin;      end
    endcase
  end
endmodule

// File: rtl/shrot_lane.sv
module shrot_lane
  import shrot_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  input  logic         cin,
  input  shrot_op_e    op,
  input  logic         two,
  output logic [W-1:0] res,
  output logic         n_flag,
  output logic         z_flag,
  output logic         v_flag,
  output logic         c_flag
);
  logic [W-1:0] s1_d, s2_d;
  logic         s1_c, s2_c;
  logic         repeat_step;
  logic         sign_moved;

  shrot_step #(.W(W)) u_first  (.din(din),  .cin(cin),  .op(op), .dout(s1_d), .cout(s1_c));
  shrot_step #(.W(W)) u_second (.din(s1_d), .cin(s1_c), .op(op), .dout(s2_d), .cout(s2_c));

  always_comb begin
    // Only codes 0..7 take a second step; inversion and pass-through do not.
    repeat_step = two && (op[3] == 1'b0);
    res    = repeat_step ? s2_d : s1_d;
    c_flag = repeat_step ? s2_c : s1_c;
    if (two)
      sign_moved = !((din[W-1:W-3] == 3'b000) || (din[W-1:W-3] == 3'b111));
    else
      sign_moved = din[W-1] ^ din[W-2];
    v_flag = (op == OP_SAL) && sign_moved;
    n_flag = res[W-1];
    z_flag = (res == '0);
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shrot_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        in_op,
  input  logic [1:0]        in_size,
  input  logic              in_two,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_carry,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_n,
  output logic              out_z,
  output logic              out_v,
  output logic              out_c
);
  localparam int LANES  = 3;
  localparam int BYTE_W = DATA_W / 4;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  shrot_op_e op_sel;
  assign op_sel = shrot_op_e'(in_op);

  logic [DATA_W-1:0] lane_word [LANES];
  logic [LANES-1:0]  lane_n, lane_z, lane_v, lane_c;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = DATA_W >> (LANES - 1 - g);
    logic [LW-1:0] lane_res;
    shrot_lane #(.W(LW)) u_lane (
      .din(in_data[LW-1:0]), .cin(in_carry), .op(op_sel), .two(in_two),
      .res(lane_res), .n_flag(lane_n[g]), .z_flag(lane_z[g]),
      .v_flag(lane_v[g]), .c_flag(lane_c[g])
    );
    if (LW < DATA_W) begin : g_upper
      assign lane_word[g] = {in_data[DATA_W-1:LW], lane_res};
    end else begin : g_full
      assign lane_word[g] = lane_res;
    end
  end

  // Next-state selection
  logic [1:0]        sel;
  logic [DATA_W-1:0] nxt_data;
  logic              nxt_n, nxt_z, nxt_v, nxt_c;
  always_comb begin
    case (in_size)
      2'd0:    sel = 2'd0;
      2'd1:    sel = 2'd1;
      default: sel = 2'd2;
    endcase
    nxt_data = lane_word[sel];
    nxt_n    = lane_n[sel];
    nxt_z    = lane_z[sel];
    nxt_v    = lane_v[sel];
    nxt_c    = lane_c[sel];
  end

  // Output register with clock enable
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_n     <= 1'b0;
      out_z     <= 1'b0;
      out_v     <= 1'b0;
      out_c     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= nxt_data;
        out_n    <= nxt_n;
        out_z    <= nxt_z;
        out_v    <= nxt_v;
        out_c    <= nxt_c;
      end
    end
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    in_valid |=> out_valid);
  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !in_valid |=> !out_valid);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !in_valid |=> ($stable(out_data) && $stable(out_c) && $stable(out_v)));
  // R2, R4, R5, R6, R7
  v_clear_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_valid && in_op != 4'd2) |=> !out_v);
  // R7
  not_carry_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_valid && in_op == 4'd8) |=> (out_c == $past(in_carry)));
  // R9
  upper_pass_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (in_valid && in_size == 2'd0) |=>
      (out_data[DATA_W-1:BYTE_W] == $past(in_data[DATA_W-1:BYTE_W])));
endmodule

// File: tb/tb_shift_rotate_unit.sv
module tb_shift_rotate_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  in_op;
  logic [1:0]  in_size;
  logic        in_two;
  logic [31:0] in_data;
  logic        in_carry;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_n, out_z, out_v, out_c;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  shift_rotate_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_size(in_size), .in_two(in_two), .in_data(in_data), .in_carry(in_carry),
    .out_valid(out_valid), .out_data(out_data), .out_n(out_n), .out_z(out_z),
    .out_v(out_v), .out_c(out_c)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h (op=%0d size=%0d two=%0d data=%h cin=%0d)",
               tag, act, exp, in_op, in_size, in_two, in_data, in_carry);
    end
  endtask

  function automatic string op_tag(input int op);
    case (op)
      0, 1:    return "R2";
      2:       return "R3";
      3:       return "R4";
      4, 5:    return "R6";
      6, 7:    return "R5";
      default: return "R7";
    endcase
  endfunction

  // Arithmetic reference model built from the requirements.
  task automatic model(input int op, input int size, input bit two,
                       input logic [31:0] d, input bit cin,
                       output logic [31:0] r, output bit n, output bit z,
                       output bit v, output bit c);
    int w, cnt;
    logic [63:0] mask, x, res;
    longint sx, prod, lo, hi;
    bit cc, nc;
    w    = (size == 0) ? 8 : (size == 1) ? 16 : 32;
    cnt  = two ? 2 : 1;
    mask = (64'd1 << w) - 1;
    x    = {32'd0, d} & mask;
    sx   = x[w-1] ? longint'(x | ~mask) : longint'(x);
    v    = 1'b0;
    c    = cin;
    res  = x;
    case (op)
      0, 2: begin
        res = (x << cnt) & mask; c = x[w-cnt];
        if (op == 2) begin
          prod = sx * (two ? 4 : 2);
          lo = -(longint'(1) << (w-1)); hi = (longint'(1) << (w-1)) - 1;
          v = (prod < lo) || (prod > hi);
        end
      end
      1: begin res = x >> cnt; c = x[cnt-1]; end
      3: begin res = 64'(sx >>> cnt) & mask; c = x[cnt-1]; end
      4: begin res = ((x << cnt) | (x >> (w-cnt))) & mask; c = res[0]; end
      5: begin res = ((x >> cnt) | (x << (w-cnt))) & mask; c = res[w-1]; end
      6, 7: begin
        cc = cin;
        for (int k = 0; k < cnt; k++) begin
          if (op == 6) begin nc = res[w-1]; res = ((res << 1) | 64'(cc)) & mask; end
          else begin nc = res[0]; res = (res >> 1) | (64'(cc) << (w-1)); end
          cc = nc;
        end
        c = cc;
      end
      8: res = ~x & mask;
      default: res = x;
    endcase
    r = d & ~mask[31:0] | res[31:0];
    n = res[w-1];
    z = (res == 64'd0);
  endtask

  // Drive at negedge, result is registered at the next posedge, sample at the following negedge.
  task automatic run(input int op, input int size, input bit two,
                     input logic [31:0] d, input bit cin);
    logic [31:0] er; bit en, ez, ev, ec;
    string t;
    in_valid = 1'b1; in_op = 4'(op); in_size = 2'(size);
    in_two = two; in_data = d; in_carry = cin;
    model(op, size, two, d, cin, er, en, ez, ev, ec);
    @(negedge clk);
    t = op_tag(op);
    check({t, " data"}, 64'(out_data), 64'(er));
    check({t, " V"},    64'(out_v),    64'(ev));
    check({t, " C"},    64'(out_c),    64'(ec));
    check("R8 N",       64'(out_n),    64'(en));
    check("R8 Z",       64'(out_z),    64'(ez));
    check("R10 valid",  64'(out_valid), 64'd1);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL R10 watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] pat, held;
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_size = '0;
    in_two = 1'b0; in_data = '0; in_carry = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 reset valid", 64'(out_valid), 64'd0);
    check("R10 reset data",  64'(out_data),  64'd0);
    check("R10 reset flags", 64'({out_n, out_z, out_v, out_c}), 64'd0);

    // R1: count select visible directly
    run(0, 0, 1'b0, 32'h0000_0001, 1'b0);
    check("R1 one step",  64'(out_data), 64'h02);
    run(0, 0, 1'b1, 32'h0000_0001, 1'b0);
    check("R1 two steps", 64'(out_data), 64'h04);
    // R3: sign change on the second step only
    run(2, 0, 1'b1, 32'h0000_0020, 1'b0);
    check("R3 late sign change", 64'(out_v), 64'd1);
    // R7: inversion ignores count
    run(8, 1, 1'b1, 32'h1234_00F0, 1'b1);
    check("R7 not ignores count", 64'(out_data), 64'h1234_FF0F);
    // R9: size 3 acts as word
    run(1, 3, 1'b0, 32'h8000_0002, 1'b0);
    check("R9 size3 word", 64'(out_data), 64'h4000_0001);

    // R10: idle cycle holds data and drops valid
    held = out_data;
    in_valid = 1'b0; in_data = 32'hDEAD_BEEF; in_op = 4'd8;
    @(negedge clk);
    check("R10 idle valid", 64'(out_valid), 64'd0);
    check("R10 idle hold",  64'(out_data),  64'(held));

    // Exhaustive byte sweep with varied upper bits (R9)
    for (int op = 0; op < 16; op++)
      for (int v = 0; v < 256; v++)
        for (int k = 0; k < 4; k++)
          run(op, 0, k[0], {8'hA5 ^ 8'(v), 8'h3C, 8'(op), 8'(v)}, k[1]);

    // Patterned half and word operands
    for (int size = 1; size < 4; size++)
      for (int op = 0; op < 16; op++)
        for (int i = 0; i < 48; i++) begin
          case (i)
            0: pat = 32'h0000_0000;
            1: pat = 32'hFFFF_FFFF;
            2: pat = 32'h8000_8000;
            3: pat = 32'h7FFF_7FFF;
            4: pat = 32'hC000_C000;
            5: pat = 32'h4000_4000;
            6: pat = 32'hA000_A000;
            7: pat = 32'h0000_0001;
            default: pat = 32'(i) * 32'h9E37_79B1 ^ (32'(op) << 11);
          endcase
          for (int k = 0; k < 4; k++) run(op, size, k[0], pat, k[1]);
        end

    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule